// File: doc/BRIEF.md
# Six-Phase Register-Transfer Processor Core

This block is a small processor that walks every instruction through an explicit sequence of register transfers. The program counter is first copied into an address latch. The instruction memory word at that address is captured into a data latch, and that word then moves into the instruction register. The counter then steps, the instruction is decoded, the ALU runs, and the result is written back. Each step takes one clock cycle, so an instruction finishes every six cycles. There is no overlap between instructions.

Instructions are 16 bits wide and operate on sixteen 16-bit general registers. The only operation is a wrapping add. Any other opcode passes through the full sequence without writing anything. A test harness fills the internal instruction memory, and may preset registers, while the core is halted. It then raises `run` and follows progress through debug outputs and a combinational register readback port.

Top module: `seqcore`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) clears the program counter, the instruction register and all sixteen registers to zero, and sets the phase to 0.
- R2: Fetch is done in three ordered transfers. Phase 0 copies the PC into the address latch. Phase 1 reads the memory word at that address into the data latch. Phase 2 moves the data latch into the instruction register, so `dbg_ir` shows the new word only after the third transfer.
- R3: While `run` is high, `dbg_phase` advances one step per clock through 0 (address), 1 (data), 2 (IR load), 3 (decode), 4 (execute) and 5 (write-back), then returns to 0.
- R4: The PC increments by one in phase 2, after the instruction has reached the IR, and wraps from 255 to 0.
- R5: Instruction fields are: opcode in bits [15:12], first source in [11:8], second source in [7:4] and destination in [3:0]. Opcode 4'b0001 writes first source plus second source into the destination. Both sources are read in decode, so a destination that is also a source receives the sum of the old values.
- R6: Addition wraps modulo 2^16, and no flag is produced.
- R7: Any opcode other than 4'b0001 writes no register, and the PC still advances.
- R8: The word 16'h1231, executed with register 2 = 5 and register 3 = 10, leaves register 1 = 15.
- R9: While `run` is low, the phase, the PC, the IR and all registers hold, apart from explicit register loads.
- R10: With `run` low and `ld_en` high, `ld_data` goes to memory word `ld_addr` when `ld_reg` is 0, or to register `ld_addr[3:0]` when `ld_reg` is 1. Loads requested while `run` is high are ignored.
- R11: `rd_val` shows the register selected by `rd_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| run | input | 1 | Enables the phase sequence |
| ld_en | input | 1 | Load strobe, honoured only while halted |
| ld_reg | input | 1 | Load target: 0 instruction memory, 1 register |
| ld_addr | input | 8 | Memory word address, or register index in bits [3:0] |
| ld_data | input | 16 | Value to load |
| rd_sel | input | 4 | Register readback index |
| rd_val | output | 16 | Selected register value |
| dbg_pc | output | 8 | Program counter |
| dbg_ir | output | 16 | Instruction register |
| dbg_phase | output | 3 | Current phase code, 0 to 5 |

## Verification
On every cycle, the embedded properties check the following:
- the phase code stays legal and returns to 0 after write-back;
- the address latch takes the PC;
- the IR takes the data latch;
- the PC steps exactly once in phase 2;
- nothing moves while halted;
- a register's readback value changes only in a write-back phase or during a halted register load.

The sum that lands in the destination, the no-op handling of foreign opcodes, the wrap of the PC and of the adder, and the rejection of loads during a run can only be shown by the bench's scenarios. These run directed cases and random programs against a reference model in the bench.

// File: rtl/seqcore.sv
module seqcore #(
  parameter int AW = 8,
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          ld_en,
  input  logic          ld_reg,
  input  logic [AW-1:0] ld_addr,
  input  logic [DW-1:0] ld_data,
  input  logic [3:0]    rd_sel,
  output logic [DW-1:0] rd_val,
  output logic [AW-1:0] dbg_pc,
  output logic [15:0]   dbg_ir,
  output logic [2:0]    dbg_phase
);
  localparam int DEPTH = 2 ** AW;
  localparam int NREG  = 16;
  localparam logic [3:0] OP_ADD = 4'b0001;

  typedef enum logic [2:0] {
    PH_ADDR   = 3'd0,
    PH_DATA   = 3'd1,
    PH_LOAD   = 3'd2,
    PH_DECODE = 3'd3,
    PH_EXEC   = 3'd4,
    PH_WB     = 3'd5
  } phase_t;

  phase_t        ph;
  logic [AW-1:0] pc, mar;
  logic [DW-1:0] mdr;
  logic [15:0]   ir;
  logic [DW-1:0] opa, opb, res;
  logic          do_wr;
  logic [DW-1:0] imem [DEPTH];
  logic [DW-1:0] rf   [NREG];

  wire [3:0] f_op  = ir[15:12];
  wire [3:0] f_sa  = ir[11:8];
  wire [3:0] f_sb  = ir[7:4];
  wire [3:0] f_dst = ir[3:0];

  assign rd_val    = rf[rd_sel];
  assign dbg_pc    = pc;
  assign dbg_ir    = ir;
  assign dbg_phase = ph;

  always_ff @(posedge clk)
    if (!rst && !run && ld_en && !ld_reg)
      imem[ld_addr] <= ld_data;

  always_ff @(posedge clk) begin
    if (rst) begin
      ph    <= PH_ADDR;
      pc    <= '0;
      mar   <= '0;
      mdr   <= '0;
      ir    <= '0;
      opa   <= '0;
      opb   <= '0;
      res   <= '0;
      do_wr <= 1'b0;
      for (int i = 0; i < NREG; i++) rf[i] <= '0;
    end else if (!run) begin
      if (ld_en && ld_reg) rf[ld_addr[3:0]] <= ld_data;
    end else begin
      case (ph)
        PH_ADDR: begin
          mar <= pc;
          ph  <= PH_DATA;
        end
        PH_DATA: begin
          mdr <= imem[mar];
          ph  <= PH_LOAD;
        end
        PH_LOAD: begin
          ir <= mdr[15:0];
          pc <= pc + 1'b1;
          ph <= PH_DECODE;
        end
        PH_DECODE: begin
          opa   <= rf[f_sa];
          opb   <= rf[f_sb];
          do_wr <= (f_op == OP_ADD);
          ph    <= PH_EXEC;
        end
        PH_EXEC: begin
          res <= opa + opb;
          ph  <= PH_WB;
        end
        PH_WB: begin
          if (do_wr) rf[f_dst] <= res;
          ph <= PH_ADDR;
        end
        default: ph <= PH_ADDR;
      endcase
    end
  end

  AST_PHASE_LEGAL: assert property (@(posedge clk) disable iff (rst)
    ph <= PH_WB);  // R3
  AST_WB_WRAPS: assert property (@(posedge clk) disable iff (rst)
    run && ph == PH_WB |=> ph == PH_ADDR);  // R3
  AST_MAR_FROM_PC: assert property (@(posedge clk) disable iff (rst)
    run && ph == PH_ADDR |=> mar == $past(pc));  // R2
  AST_IR_FROM_MDR: assert property (@(posedge clk) disable iff (rst)
    run && ph == PH_LOAD |=> ir == $past(mdr[15:0]));  // R2
  AST_PC_STEP: assert property (@(posedge clk) disable iff (rst)
    run && ph == PH_LOAD |=> pc == AW'($past(pc) + 1'b1));  // R4
  AST_PC_STILL: assert property (@(posedge clk) disable iff (rst)
    !(run && ph == PH_LOAD) |=> $stable(pc));  // R4
  AST_HALT_HOLD: assert property (@(posedge clk) disable iff (rst)
    !run |=> $stable(ph) && $stable(pc) && $stable(ir));  // R9
  AST_RF_QUIET: assert property (@(posedge clk) disable iff (rst)
    (run && !(ph == PH_WB && do_wr)) || (!run && !(ld_en && ld_reg))
      |=> (rd_sel != $past(rd_sel)) || $stable(rd_val));  // R7
endmodule

// File: tb/seqcore_test.sv
module seqcore_test;
  logic        clk = 0;
  logic        rst = 1, run = 0, ld_en = 0, ld_reg = 0;
  logic [7:0]  ld_addr = 0;
  logic [15:0] ld_data = 0;
  logic [3:0]  rd_sel = 0;
  logic [15:0] rd_val, dbg_ir;
  logic [7:0]  dbg_pc;
  logic [2:0]  dbg_phase;

  int checks = 0, failures = 0;
  bit done = 0;

  logic [15:0] m_mem [256];
  logic [15:0] m_rf  [16];
  logic [7:0]  m_pc;
  logic [15:0] m_ir;

  seqcore uut (.clk(clk), .rst(rst), .run(run), .ld_en(ld_en), .ld_reg(ld_reg),
    .ld_addr(ld_addr), .ld_data(ld_data), .rd_sel(rd_sel), .rd_val(rd_val),
    .dbg_pc(dbg_pc), .dbg_ir(dbg_ir), .dbg_phase(dbg_phase));

  always #4 clk = ~clk;

  function automatic logic [15:0] add16(logic [15:0] a, logic [15:0] b);
    logic [16:0] s = {1'b0, a} + {1'b0, b};
    return s[15:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic model_step(input int n);
    for (int k = 0; k < n; k++) begin
      m_ir = m_mem[m_pc];
      m_pc = m_pc + 8'd1;
      if (m_ir[15:12] == 4'b0001)
        m_rf[m_ir[3:0]] = add16(m_rf[m_ir[11:8]], m_rf[m_ir[7:4]]);
    end
  endtask

  task automatic do_reset();
    rst = 1; tick(2); rst = 0;
    m_pc = 0; m_ir = 0;
    for (int i = 0; i < 16; i++) m_rf[i] = 0;
  endtask

  task automatic ld_mem(input logic [7:0] a, input logic [15:0] d);
    ld_en = 1; ld_reg = 0; ld_addr = a; ld_data = d;
    tick(1); ld_en = 0;
    if (!run) m_mem[a] = d;
  endtask

  task automatic ld_rf(input logic [3:0] r, input logic [15:0] d);
    ld_en = 1; ld_reg = 1; ld_addr = {4'd0, r}; ld_data = d;
    tick(1); ld_en = 0;
    if (!run) m_rf[r] = d;
  endtask

  task automatic run_instr(input int n);
    run = 1; tick(6 * n); run = 0;
    model_step(n);
  endtask

  task automatic check_all(input string req);
    for (int i = 0; i < 16; i++) begin
      rd_sel = 4'(i); #1;
      chk(rd_val === m_rf[i], req, rd_val, m_rf[i]);
    end
    chk(dbg_pc === m_pc, req, dbg_pc, m_pc);
    chk(dbg_ir === m_ir, req, dbg_ir, m_ir);
  endtask

  task automatic read_reg(input logic [3:0] r, input logic [15:0] exp, input string req);
    rd_sel = r; #1;
    chk(rd_val === exp, req, rd_val, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks + 1, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_0042));
    for (int i = 0; i < 256; i++) m_mem[i] = 0;
    tick(1);
    do_reset();
    // R1 reset state
    chk(dbg_phase === 3'd0, "R1", dbg_phase, 0);
    check_all("R1");
    for (int i = 0; i < 256; i++) ld_mem(8'(i), 16'h0000);

    // R8 worked example, with R2 R3 R4 fetch ordering
    ld_rf(4'd2, 16'd5);
    ld_rf(4'd3, 16'd10);
    ld_mem(8'd0, 16'h1231);
    rd_sel = 4'd1;
    run = 1;
    for (int k = 1; k <= 6; k++) begin
      tick(1);
      chk(dbg_phase === 3'(k % 6), "R3", dbg_phase, k % 6);
      if (k == 2) chk(dbg_ir === 16'h0000, "R2", dbg_ir, 0);
      if (k == 3) begin
        chk(dbg_ir === 16'h1231, "R2", dbg_ir, 16'h1231);
        chk(dbg_pc === 8'd1, "R4", dbg_pc, 1);
      end
      if (k == 5) begin
        #1; chk(rd_val === 16'd0, "R11", rd_val, 0);
      end
    end
    run = 0;
    model_step(1);
    read_reg(4'd1, 16'd15, "R8");
    check_all("R5");

    // R6 wrap of the sum
    ld_rf(4'd4, 16'hFFFF);
    ld_rf(4'd5, 16'h0002);
    ld_mem(8'd1, 16'h1456);
    run_instr(1);
    read_reg(4'd6, 16'h0001, "R6");

    // R7 foreign opcode
    ld_mem(8'd2, 16'h7451);
    run_instr(1);
    read_reg(4'd1, 16'd15, "R7");
    chk(dbg_pc === 8'd3, "R7", dbg_pc, 3);

    // R5 destination equal to a source
    ld_mem(8'd3, 16'h1222);
    run_instr(1);
    read_reg(4'd2, 16'd10, "R5");

    // R9 halt mid instruction
    ld_mem(8'd4, 16'h1237);
    run = 1; tick(3); run = 0;
    for (int k = 0; k < 4; k++) begin
      tick(1);
      chk(dbg_phase === 3'd3, "R9", dbg_phase, 3);
      chk(dbg_pc === 8'd5, "R9", dbg_pc, 5);
    end
    run = 1; tick(3); run = 0;
    model_step(1);
    read_reg(4'd7, 16'd20, "R9");
    check_all("R9");

    // R10 loads during a run are dropped
    ld_mem(8'd5, 16'h0000);
    ld_mem(8'd6, 16'h0000);
    run = 1;
    ld_rf(4'd9, 16'hBEEF);
    ld_mem(8'd6, 16'h1999);
    tick(4); run = 0;
    model_step(1);
    read_reg(4'd9, 16'h0000, "R10");
    run_instr(1);
    check_all("R10");

    // random programs: R4 wrap, R5, R7
    for (int round = 0; round < 3; round++) begin
      do_reset();
      for (int r = 0; r < 16; r++) ld_rf(4'(r), 16'($urandom));
      for (int a = 0; a < 256; a++) begin
        logic [15:0] w = 16'($urandom);
        if ($urandom % 2 == 0) w[15:12] = 4'b0001;
        ld_mem(8'(a), w);
      end
      run_instr(300);
      check_all("R4");
    end

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule